// File: doc/BRIEF.md
# Opcode-Menu SPI Cycle Sequencer

This block is a software-driven SPI flash master. A host first loads a table of eight opcodes. It also loads a two-bit cycle type for each table entry, a prefix opcode and an address. Then it starts a cycle by writing a control word. The control word names a table entry and can ask for a data phase. In that phase the engine either sends bytes from a 64-byte staging buffer or stores the bytes it receives into that buffer. A prefix opcode, such as a write-enable, can go out in its own chip-select frame just before the main frame, with no other traffic in between.

Progress shows in a status word. A busy bit follows the cycle. Completion and misuse are reported through sticky flags that are cleared by writing one to them. A lock bit freezes the opcode table, the type table and the prefix opcode until the next reset. The serial side runs in SPI mode 0. The half period of the serial clock comes from an input divider value.

Top module: `spi_opmenu_seq`

## Requirements
- R1: After reset the status word reads 0, chip select is high and the serial clock is low. Chip select stays high whenever no cycle is running.
- R2: Table entry n's opcode sits at bits 8n+7:8n of the table write word. Its type sits at bits 2n+1:2n of the type write word. Type codes: 0 = read without address, 1 = write without address, 2 = read with address, 3 = write with address. The main frame starts with the opcode of the selected entry.
- R3: Control word fields: start at bit 1, prefix request at bit 2, entry index at bits 6:4, data byte count minus one at bits 13:8, data phase enable at bit 14.
- R4: Types 2 and 3 send the low 24 bits of the address register after the opcode, most significant byte first. Bits 31:24 are never sent. Types 0 and 1 send no address.
- R5: With data phase enable clear, the frame holds only the opcode, plus the address for types 2 and 3.
- R6: A write-type cycle with data enabled sends count+1 buffer bytes after the header. Byte i comes from byte lane i mod 4 (bits 8k+7:8k for lane k) of buffer word i/4.
- R7: A read-type cycle with data enabled sends zero bytes during the data phase. It stores received byte i into lane i mod 4 of word i/4. Buffer bytes beyond the count are left unchanged.
- R8: With the prefix request set, the prefix opcode goes out alone in one chip-select frame. The main frame follows directly after it.
- R9: Status bit 0 is high while a cycle runs. Bit 2 (done) is set when the cycle ends. Bits 2 and 3 (error) are cleared by writing 1 to them through the status write port.
- R10: A start issued while a cycle runs sets status bit 3. It does not change or add any frame.
- R11: Writing 1 to status bit 15 sets the lock, which only reset clears. While locked, writes to the opcode table, type table and prefix opcode are ignored.
- R12: SPI mode 0. The clock idles low. Data is captured on rising edges and changed on falling edges. Each clock high phase lasts clk_div+1 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_div | input | DIV_W | Serial clock half period minus one, in core cycles |
| menu_we | input | 1 | Opcode table write strobe |
| menu_wdata | input | MENU_N*8 | Opcode table contents |
| type_we | input | 1 | Type table write strobe |
| type_wdata | input | MENU_N*2 | Type table contents |
| pfx_we | input | 1 | Prefix opcode write strobe |
| pfx_wdata | input | 8 | Prefix opcode |
| addr_we | input | 1 | Address write strobe |
| addr_wdata | input | 32 | Flash address (low 24 bits used) |
| buf_we | input | 1 | Staging buffer word write strobe |
| buf_widx | input | WIDX_W | Buffer word index for writes |
| buf_wdata | input | 32 | Buffer write word |
| buf_ridx | input | WIDX_W | Buffer word index for reads |
| buf_rdata | output | 32 | Buffer read word |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word |
| sts_we | input | 1 | Status write strobe (clear flags, set lock) |
| sts_wdata | input | 16 | Status write value |
| sts | output | 16 | Status word |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The assertions take four things for granted. The host does not write the staging buffer while a cycle runs. clk_div is held steady for the whole of a cycle. The flash side changes its data line only after falling clock edges. The table and prefix are reprogrammed only while the engine is idle. The bench keeps to all four. Its serial model updates its output only on falling edges or on chip-select assertion. It changes configuration only between cycles, with the one exception of the deliberate second start used for R10. It alters the divider only between completed cycles.

// File: rtl/sos_pkg.sv
package sos_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_PFX  = 3'd1,
    S_GAP  = 3'd2,
    S_OPC  = 3'd3,
    S_ADR  = 3'd4,
    S_DAT  = 3'd5,
    S_END  = 3'd6
  } seq_state_t;

  localparam int CTL_GO   = 1;
  localparam int CTL_PFX  = 2;
  localparam int CTL_IDX  = 4;
  localparam int CTL_CNT  = 8;
  localparam int CTL_DEN  = 14;

  localparam int STS_BUSY = 0;
  localparam int STS_DONE = 2;
  localparam int STS_ERR  = 3;
  localparam int STS_LOCK = 15;

  localparam int ADR_BYTES = 3;
endpackage

// File: rtl/sos_byte_shifter.sv
module sos_byte_shifter #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             start,
  input  logic [7:0]       tx_byte,
  input  logic             miso,
  output logic             sclk,
  output logic             mosi,
  output logic             busy,
  output logic             done,
  output logic [7:0]       rx_byte
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [2:0]       bit_q, bit_d;
  logic [7:0]       sh_q, sh_d, rx_q, rx_d;
  logic             sclk_q, sclk_d, busy_q, busy_d, done_q, done_d;

  always_comb begin
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    rx_d   = rx_q;
    sclk_d = sclk_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (start && !busy_q) begin
      busy_d = 1'b1;
      sclk_d = 1'b0;
      cnt_d  = '0;
      bit_d  = '0;
      sh_d   = tx_byte;
    end else if (busy_q) begin
      if (cnt_q == div) begin
        cnt_d = '0;
        if (!sclk_q) begin
          sclk_d = 1'b1;
          rx_d   = {rx_q[6:0], miso};
        end else begin
          sclk_d = 1'b0;
          sh_d   = {sh_q[6:0], 1'b0};
          bit_d  = bit_q + 3'd1;
          if (bit_q == 3'd7) begin
            busy_d = 1'b0;
            done_d = 1'b1;
          end
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
      sclk_q <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      rx_q   <= rx_d;
      sclk_q <= sclk_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign sclk    = sclk_q;
  assign mosi    = sh_q[7];
  assign busy    = busy_q;
  assign done    = done_q;
  assign rx_byte = rx_q;

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sclk_q); // R12
  AST_DONE_ENDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q && !sclk_q); // R12
endmodule

// File: rtl/sos_data_buf.sv
module sos_data_buf #(
  parameter int WORDS = 16,
  localparam int WIDX_W = $clog2(WORDS),
  localparam int BIDX_W = $clog2(WORDS * 4)
) (
  input  logic              clk,
  input  logic              hw_we,
  input  logic [WIDX_W-1:0] hw_idx,
  input  logic [31:0]       hw_data,
  input  logic [WIDX_W-1:0] rd_idx,
  output logic [31:0]       rd_data,
  input  logic              eng_we,
  input  logic [BIDX_W-1:0] eng_bidx,
  input  logic [7:0]        eng_wbyte,
  output logic [7:0]        eng_rbyte
);
  logic [31:0] mem [WORDS];
  logic [31:0] eng_word;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (eng_we && (eng_bidx[BIDX_W-1:2] == WIDX_W'(w))) begin
        mem[w][{eng_bidx[1:0], 3'b000} +: 8] <= eng_wbyte;
      end else if (hw_we && (hw_idx == WIDX_W'(w))) begin
        mem[w] <= hw_data;
      end
    end
  end

  assign rd_data   = mem[rd_idx];
  assign eng_word  = mem[eng_bidx[BIDX_W-1:2]];
  assign eng_rbyte = eng_word[{eng_bidx[1:0], 3'b000} +: 8];
endmodule

// File: rtl/spi_opmenu_seq.sv
module spi_opmenu_seq
  import sos_pkg::*;
#(
  parameter int MENU_N    = 8,
  parameter int BUF_WORDS = 16,
  parameter int DIV_W     = 8,
  localparam int IDX_W    = $clog2(MENU_N),
  localparam int WIDX_W   = $clog2(BUF_WORDS),
  localparam int CNT_W    = $clog2(BUF_WORDS * 4)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DIV_W-1:0]      clk_div,
  input  logic                  menu_we,
  input  logic [MENU_N*8-1:0]   menu_wdata,
  input  logic                  type_we,
  input  logic [MENU_N*2-1:0]   type_wdata,
  input  logic                  pfx_we,
  input  logic [7:0]            pfx_wdata,
  input  logic                  addr_we,
  input  logic [31:0]           addr_wdata,
  input  logic                  buf_we,
  input  logic [WIDX_W-1:0]     buf_widx,
  input  logic [31:0]           buf_wdata,
  input  logic [WIDX_W-1:0]     buf_ridx,
  output logic [31:0]           buf_rdata,
  input  logic                  ctl_we,
  input  logic [15:0]           ctl_wdata,
  input  logic                  sts_we,
  input  logic [15:0]           sts_wdata,
  output logic [15:0]           sts,
  output logic                  spi_sclk,
  output logic                  spi_cs_n,
  output logic                  spi_mosi,
  input  logic                  spi_miso
);
  localparam logic [CNT_W-1:0] ADR_LAST = CNT_W'(ADR_BYTES - 1);

  seq_state_t          st_q, st_d;
  logic [MENU_N*8-1:0] menu_q;
  logic [MENU_N*2-1:0] types_q;
  logic [7:0]          pfx_q, tx_byte, op_byte, buf_byte, rx_byte;
  logic [23:0]         addr_q, adr_sh_q, adr_sh_d;
  logic [IDX_W-1:0]    idx_q, idx_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d, bcnt_q, bcnt_d;
  logic [1:0]          typ;
  logic                den_q, den_d, cs_n_q, cs_n_d, launch_q, launch_d;
  logic                done_q, done_d, err_q, err_d, lock_q, lock_d;
  logic                go_req, busy, sh_done, sh_busy, eng_we;
  logic                unused_bits;

  assign unused_bits = ^{addr_wdata[31:24], ctl_wdata[15], ctl_wdata[7],
                         ctl_wdata[3], ctl_wdata[0], sts_wdata[14:4], sts_wdata[1:0]};

  assign go_req  = ctl_we && ctl_wdata[CTL_GO];
  assign busy    = (st_q != S_IDLE);
  assign typ     = types_q[{idx_q, 1'b0} +: 2];
  assign op_byte = menu_q[{idx_q, 3'b000} +: 8];

  // configuration registers, frozen by the lock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      menu_q  <= '0;
      types_q <= '0;
      pfx_q   <= '0;
      addr_q  <= '0;
    end else begin
      if (menu_we && !lock_q) menu_q  <= menu_wdata;
      if (type_we && !lock_q) types_q <= type_wdata;
      if (pfx_we && !lock_q)  pfx_q   <= pfx_wdata;
      if (addr_we)            addr_q  <= addr_wdata[23:0];
    end
  end

  // status flags
  always_comb begin
    done_d = done_q && !(sts_we && sts_wdata[STS_DONE]);
    err_d  = err_q && !(sts_we && sts_wdata[STS_ERR]);
    lock_d = lock_q || (sts_we && sts_wdata[STS_LOCK]);
    if (st_q == S_END)    done_d = 1'b1;
    if (go_req && busy)   err_d  = 1'b1;
  end

  // cycle sequencer
  always_comb begin
    st_d     = st_q;
    idx_d    = idx_q;
    cnt_d    = cnt_q;
    den_d    = den_q;
    bcnt_d   = bcnt_q;
    adr_sh_d = adr_sh_q;
    cs_n_d   = cs_n_q;
    launch_d = 1'b0;
    eng_we   = 1'b0;
    case (st_q)
      S_IDLE: if (go_req) begin
        idx_d    = ctl_wdata[CTL_IDX +: IDX_W];
        cnt_d    = ctl_wdata[CTL_CNT +: CNT_W];
        den_d    = ctl_wdata[CTL_DEN];
        adr_sh_d = addr_q;
        bcnt_d   = '0;
        cs_n_d   = 1'b0;
        launch_d = 1'b1;
        st_d     = ctl_wdata[CTL_PFX] ? S_PFX : S_OPC;
      end
      S_PFX: if (sh_done) begin
        cs_n_d = 1'b1;
        st_d   = S_GAP;
      end
      S_GAP: begin
        cs_n_d   = 1'b0;
        launch_d = 1'b1;
        st_d     = S_OPC;
      end
      S_OPC: if (sh_done) begin
        if (typ[1]) begin
          launch_d = 1'b1;
          st_d     = S_ADR;
        end else if (den_q) begin
          launch_d = 1'b1;
          st_d     = S_DAT;
        end else begin
          cs_n_d = 1'b1;
          st_d   = S_END;
        end
      end
      S_ADR: if (sh_done) begin
        adr_sh_d = {adr_sh_q[15:0], 8'h00};
        if (bcnt_q == ADR_LAST) begin
          bcnt_d = '0;
          if (den_q) begin
            launch_d = 1'b1;
            st_d     = S_DAT;
          end else begin
            cs_n_d = 1'b1;
            st_d   = S_END;
          end
        end else begin
          bcnt_d   = bcnt_q + 1'b1;
          launch_d = 1'b1;
        end
      end
      S_DAT: if (sh_done) begin
        eng_we = !typ[0];
        if (bcnt_q == cnt_q) begin
          cs_n_d = 1'b1;
          st_d   = S_END;
        end else begin
          bcnt_d   = bcnt_q + 1'b1;
          launch_d = 1'b1;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_comb begin
    case (st_q)
      S_PFX:   tx_byte = pfx_q;
      S_OPC:   tx_byte = op_byte;
      S_ADR:   tx_byte = adr_sh_q[23:16];
      S_DAT:   tx_byte = typ[0] ? buf_byte : 8'h00;
      default: tx_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      idx_q    <= '0;
      cnt_q    <= '0;
      den_q    <= 1'b0;
      bcnt_q   <= '0;
      adr_sh_q <= '0;
      cs_n_q   <= 1'b1;
      launch_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      lock_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      idx_q    <= idx_d;
      cnt_q    <= cnt_d;
      den_q    <= den_d;
      bcnt_q   <= bcnt_d;
      adr_sh_q <= adr_sh_d;
      cs_n_q   <= cs_n_d;
      launch_q <= launch_d;
      done_q   <= done_d;
      err_q    <= err_d;
      lock_q   <= lock_d;
    end
  end

  sos_byte_shifter #(.DIV_W(DIV_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .div     (clk_div),
    .start   (launch_q),
    .tx_byte (tx_byte),
    .miso    (spi_miso),
    .sclk    (spi_sclk),
    .mosi    (spi_mosi),
    .busy    (sh_busy),
    .done    (sh_done),
    .rx_byte (rx_byte)
  );

  sos_data_buf #(.WORDS(BUF_WORDS)) u_buf (
    .clk       (clk),
    .hw_we     (buf_we),
    .hw_idx    (buf_widx),
    .hw_data   (buf_wdata),
    .rd_idx    (buf_ridx),
    .rd_data   (buf_rdata),
    .eng_we    (eng_we),
    .eng_bidx  (bcnt_q),
    .eng_wbyte (rx_byte),
    .eng_rbyte (buf_byte)
  );

  assign spi_cs_n = cs_n_q;
  assign sts = {lock_q, 11'd0, err_q, done_q, 1'b0, busy};

  AST_CS_HIGH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE) |-> cs_n_q); // R1
  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wdata[CTL_GO] && busy) |=> err_q); // R10
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q); // R11
  AST_LOCKED_MENU: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && (menu_we || type_we || pfx_we)) |=> $stable(menu_q) && $stable(types_q) && $stable(pfx_q)); // R11
  AST_DONE_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> cs_n_q && !busy); // R9
  AST_LAUNCH_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    launch_q |-> !sh_busy && !cs_n_q); // R12
endmodule

// File: tb/sim_spi_opmenu_seq.sv
module sim_spi_opmenu_seq;
  localparam time CLK_P = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  clk_div = 8'd1;
  logic        menu_we = 1'b0, type_we = 1'b0, pfx_we = 1'b0, addr_we = 1'b0;
  logic [63:0] menu_wdata = '0;
  logic [15:0] type_wdata = '0;
  logic [7:0]  pfx_wdata = '0;
  logic [31:0] addr_wdata = '0;
  logic        buf_we = 1'b0;
  logic [3:0]  buf_widx = '0, buf_ridx = '0;
  logic [31:0] buf_wdata = '0, buf_rdata;
  logic        ctl_we = 1'b0, sts_we = 1'b0;
  logic [15:0] ctl_wdata = '0, sts_wdata = '0, sts;
  logic        spi_sclk, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b0;

  int nchk = 0, nfail = 0;

  always #(CLK_P / 2) clk = ~clk;

  spi_opmenu_seq u0 (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div),
    .menu_we(menu_we), .menu_wdata(menu_wdata),
    .type_we(type_we), .type_wdata(type_wdata),
    .pfx_we(pfx_we), .pfx_wdata(pfx_wdata),
    .addr_we(addr_we), .addr_wdata(addr_wdata),
    .buf_we(buf_we), .buf_widx(buf_widx), .buf_wdata(buf_wdata),
    .buf_ridx(buf_ridx), .buf_rdata(buf_rdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .sts_we(sts_we), .sts_wdata(sts_wdata), .sts(sts),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  function automatic logic [7:0] pat(input int k);
    return 8'((k * 37 + 5) & 255);
  endfunction
  function automatic logic [7:0] wb(input int i);
    return 8'((i * 7 + 3) & 255);
  endfunction
  function automatic logic [15:0] mk_ctl(input int pfx, input int idx, input int cm1, input int den);
    return 16'((den << 14) | (cm1 << 8) | (idx << 4) | (pfx << 2) | 2);
  endfunction

  // flash-side model: frames captured on rising edges, reply on falling edges
  logic [7:0] fb [8][80];
  int         flen [8];
  int         nfr = 0, nbits = 0;
  logic [7:0] srx = '0;

  always @(posedge spi_sclk or posedge spi_cs_n) begin
    if (spi_cs_n) begin
      if (nbits > 0) begin
        flen[nfr % 8] = nbits / 8;
        nfr = nfr + 1;
      end
      nbits = 0;
    end else begin
      srx = {srx[6:0], spi_mosi};
      nbits = nbits + 1;
      if (nbits % 8 == 0 && nbits / 8 <= 80) fb[nfr % 8][nbits / 8 - 1] = srx;
    end
  end

  always @(negedge spi_sclk or negedge spi_cs_n) begin
    logic [7:0] b;
    b = pat(nbits / 8);
    spi_miso = b[7 - (nbits % 8)];
  end

  // high-phase width monitor
  int hc = 0, gap_bad = 0, gap_seen = 0;
  logic ps = 1'b0;
  always @(negedge clk) begin
    if (spi_sclk) hc = hc + 1;
    else if (ps) begin
      if (hc != int'(clk_div) + 1) gap_bad = gap_bad + 1;
      gap_seen = gap_seen + 1;
      hc = 0;
    end
    ps = spi_sclk;
  end

  initial begin
    #(CLK_P * 190000);
    $display("FAIL watchdog expired (req none) actual=hung expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk + 1, nfail + 1);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [7:0] eb [80];
  int         en;
  logic [31:0] model [16];

  task automatic cmp_frame(input int slot, input string req);
    int bad;
    bad = -1;
    for (int k = 0; k < en; k++) if (bad < 0 && fb[slot % 8][k] !== eb[k]) bad = k;
    if (flen[slot % 8] != en) chk(0, {req, " frame length"}, 64'(flen[slot % 8]), 64'(en));
    else if (bad >= 0) chk(0, {req, " frame byte"}, 64'(fb[slot % 8][bad]), 64'(eb[bad]));
    else chk(1, req, 0, 0);
  endtask

  task automatic wr_ctl(input logic [15:0] c);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = c;
    @(negedge clk); ctl_we = 1'b0;
  endtask
  task automatic wr_sts(input logic [15:0] v);
    @(negedge clk); sts_we = 1'b1; sts_wdata = v;
    @(negedge clk); sts_we = 1'b0;
  endtask
  task automatic wait_done();
    int t;
    t = 0;
    while (!sts[2] && t < 40000) begin @(negedge clk); t++; end
    if (!sts[2]) chk(0, "R9 done timeout", 0, 1);
  endtask
  task automatic run(input logic [15:0] c, output int base);
    base = nfr;
    wr_ctl(c);
    wait_done();
    wr_sts(16'h0004);
  endtask
  task automatic hdr(input int idx, input int typ);
    en = 0;
    eb[en++] = 8'(8'hA0 + idx);
    if (typ >= 2) begin eb[en++] = 8'h12; eb[en++] = 8'h34; eb[en++] = 8'h56; end
  endtask
  task automatic fill_buf();
    for (int w = 0; w < 16; w++) begin
      model[w] = {wb(4*w+3), wb(4*w+2), wb(4*w+1), wb(4*w)};
      @(negedge clk); buf_we = 1'b1; buf_widx = 4'(w); buf_wdata = model[w];
    end
    @(negedge clk); buf_we = 1'b0;
  endtask
  task automatic check_buf(input string req);
    for (int w = 0; w < 16; w++) begin
      buf_ridx = 4'(w);
      #1;
      chk(buf_rdata === model[w], req, 64'(buf_rdata), 64'(model[w]));
    end
  endtask

  initial begin
    int base;
    int cnts [7] = '{1, 2, 3, 4, 5, 17, 64};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sts === 16'h0000, "R1 status after reset", 64'(sts), 0);
    chk(spi_cs_n === 1'b1, "R1 cs after reset", 64'(spi_cs_n), 1);
    chk(spi_sclk === 1'b0, "R1 sclk after reset", 64'(spi_sclk), 0);

    // table: opcode A0+n, type n mod 4
    @(negedge clk);
    menu_we = 1'b1; type_we = 1'b1; pfx_we = 1'b1; addr_we = 1'b1;
    for (int n = 0; n < 8; n++) begin
      menu_wdata[8*n +: 8] = 8'(8'hA0 + n);
      type_wdata[2*n +: 2] = 2'(n % 4);
    end
    pfx_wdata = 8'h06; addr_wdata = 32'hFF12_3456;
    @(negedge clk);
    menu_we = 1'b0; type_we = 1'b0; pfx_we = 1'b0; addr_we = 1'b0;
    fill_buf();

    // R2 R4 R5: every entry without data phase
    for (int n = 0; n < 8; n++) begin
      run(mk_ctl(0, n, 0, 0), base);
      chk(nfr - base == 1, "R5 one frame", 64'(nfr - base), 1);
      hdr(n, n % 4);
      cmp_frame(base, "R2 R4 R5 opcode/address frame");
      chk(spi_cs_n === 1'b1 && spi_sclk === 1'b0, "R1 idle after cycle", 64'({spi_cs_n, spi_sclk}), 2);
    end

    // R6 R3: write data sweep on both write types
    foreach (cnts[c]) begin
      for (int v = 0; v < 2; v++) begin
        int idx;
        idx = (v == 0) ? 1 : 3;
        run(mk_ctl(0, idx, cnts[c] - 1, 1), base);
        hdr(idx, idx);
        for (int i = 0; i < cnts[c]; i++) eb[en++] = wb(i);
        cmp_frame(base, "R6 R3 write data frame");
      end
    end

    // R7: read with address, 11 bytes
    run(mk_ctl(0, 2, 10, 1), base);
    hdr(2, 2);
    for (int i = 0; i < 11; i++) eb[en++] = 8'h00;
    cmp_frame(base, "R7 read frame sends zeros");
    for (int i = 0; i < 11; i++) model[i / 4][8*(i % 4) +: 8] = pat(4 + i);
    check_buf("R7 captured bytes in lane order");

    // R7: read without address, 5 bytes
    run(mk_ctl(0, 0, 4, 1), base);
    for (int i = 0; i < 5; i++) model[i / 4][8*(i % 4) +: 8] = pat(1 + i);
    check_buf("R7 unaddressed read capture");
    fill_buf();

    // R8: prefix frame then main frame
    run(mk_ctl(1, 1, 0, 0), base);
    chk(nfr - base == 2, "R8 two frames", 64'(nfr - base), 2);
    en = 1; eb[0] = 8'h06;
    cmp_frame(base, "R8 prefix frame");
    hdr(1, 1);
    cmp_frame(base + 1, "R8 main frame after prefix");
    run(mk_ctl(1, 3, 1, 1), base);
    en = 1; eb[0] = 8'h06;
    cmp_frame(base, "R8 prefix before write");
    hdr(3, 3); eb[en++] = wb(0); eb[en++] = wb(1);
    cmp_frame(base + 1, "R8 write after prefix");

    // R9: busy, done, write-one-to-clear
    wr_ctl(mk_ctl(0, 0, 0, 0));
    chk(sts[0] === 1'b1 && sts[2] === 1'b0, "R9 busy during cycle", 64'(sts), 1);
    wait_done();
    @(negedge clk);
    chk(sts[0] === 1'b0 && sts[2] === 1'b1, "R9 done at end", 64'(sts), 4);
    wr_sts(16'h0000);
    chk(sts[2] === 1'b1, "R9 zero write keeps done", 64'(sts), 4);
    wr_sts(16'h0004);
    chk(sts === 16'h0000, "R9 done cleared", 64'(sts), 0);

    // R10: start while busy
    clk_div = 8'd3;
    base = nfr;
    wr_ctl(mk_ctl(0, 3, 63, 1));
    repeat (10) @(negedge clk);
    wr_ctl(mk_ctl(0, 0, 0, 0));
    chk(sts[3] === 1'b1, "R10 error on busy start", 64'(sts), 8);
    wait_done();
    @(negedge clk);
    chk(nfr - base == 1, "R10 no extra frame", 64'(nfr - base), 1);
    hdr(3, 3);
    for (int i = 0; i < 64; i++) eb[en++] = wb(i);
    cmp_frame(base, "R10 running cycle unchanged");
    wr_sts(16'h000C);
    chk(sts === 16'h0000, "R9 error cleared", 64'(sts), 0);

    // R12: divider sweep
    for (int d = 0; d < 4; d++) begin
      int gb, gs;
      clk_div = 8'(d);
      gb = gap_bad; gs = gap_seen;
      run(mk_ctl(0, 3, 2, 1), base);
      hdr(3, 3); eb[en++] = wb(0); eb[en++] = wb(1); eb[en++] = wb(2);
      cmp_frame(base, "R12 frame at divider");
      chk(gap_bad == gb && gap_seen - gs == 56, "R12 high phase width",
          64'(gap_bad - gb), 0);
    end
    clk_div = 8'd1;

    // R11: lock
    wr_sts(16'h8000);
    chk(sts === 16'h8000, "R11 lock set", 64'(sts), 16'h8000);
    @(negedge clk);
    menu_we = 1'b1; type_we = 1'b1; pfx_we = 1'b1;
    menu_wdata = {8{8'h55}}; type_wdata = 16'h0000; pfx_wdata = 8'h99;
    @(negedge clk);
    menu_we = 1'b0; type_we = 1'b0; pfx_we = 1'b0;
    wr_sts(16'h0000);
    chk(sts[15] === 1'b1, "R11 lock not cleared by write", 64'(sts), 16'h8000);
    run(mk_ctl(1, 6, 0, 0), base);
    en = 1; eb[0] = 8'h06;
    cmp_frame(base, "R11 locked prefix kept");
    hdr(6, 2);
    cmp_frame(base + 1, "R11 locked opcode and type kept");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule